// File: doc/BRIEF.md
# Temperature Alarm and Interrupt Status Controller

This block watches a stream of signed temperature results and raises sticky alarm status when a result leaves a programmable window. Each result that arrives with a valid strobe is compared, in two's complement, against a high threshold and a low threshold held in the block. A result above the high threshold latches a "too hot" bit. A result below the low threshold latches a "too cold" bit. A third sticky bit records that the downstream sample buffer is almost full. How that bit is raised and cleared is chosen at run time.

Each status bit is gated by its own interrupt-enable bit, and the gated bits are ORed into an internal alarm flag. When a 2-bit pin mode field selects the special function, the alarm flag pulls an open-drain interrupt pin low. A status read clears all three bits. Optionally, a read of buffered data also clears the almost-full bit. If a new event arrives in the same cycle as a clear, the new event wins, so no alarm is lost.

Top module: `tmp_alarm_ctrl`

## Requirements
- R1: After reset the high threshold reads 0x7FFF, the low threshold reads 0x8000, the enables and all status bits read 0, and the interrupt pin is released (`int_pull_low` = 0).
- R2: A result strobed with `smp_valid` that is strictly greater than the high threshold (signed compare) sets `status[0]` on the next cycle. A result equal to the threshold does not set it.
- R3: A strobed result that is strictly less than the low threshold (signed compare) sets `status[1]` on the next cycle. A result equal to the threshold does not set it.
- R4: Status bits are sticky: a later in-range result leaves them set. A pulse on `stat_rd` clears all three bits on the next cycle.
- R5: `alarm_flag` is 1 exactly when some `status[i]` and `ien[i]` are both 1 (bit 0 high, bit 1 low, bit 2 almost-full).
- R6: `int_pull_low` is 1 only when `alarm_flag` is 1 and `pin_mode` is 2'b11. The other pin mode values are 00 (high-impedance input), 01 (open-drain output) and 10 (input with pulldown), and each of them keeps the pin released.
- R7: Level policy (`af_edge_mode` = 0): every `smp_valid` with `fifo_af` high sets `status[2]` on the next cycle, including after a clear while the condition persists.
- R8: Edge policy (`af_edge_mode` = 1): `status[2]` is set only on the cycle after `fifo_af` rises from 0 to 1. Samples during a persisting condition do not set it again.
- R9: With `af_rdclr_en` = 1, a `fifo_rd` pulse clears `status[2]` only. With `af_rdclr_en` = 0, `fifo_rd` has no effect on status.
- R10: When a set and a clear of the same status bit happen in one cycle, the bit ends up set.
- R11: `thr_hi_wr` and `thr_lo_wr` load `thr_wdata` into the respective threshold, and the new value is visible on the next cycle. `ien_wr` loads `ien_wdata` the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | New temperature result strobe |
| smp_data | input | 16 | Temperature result, two's complement |
| thr_hi_wr | input | 1 | Load high threshold |
| thr_lo_wr | input | 1 | Load low threshold |
| thr_wdata | input | 16 | Threshold write data |
| ien_wr | input | 1 | Load interrupt enables |
| ien_wdata | input | 3 | Interrupt enable write data |
| pin_mode | input | 2 | Interrupt pin mode field |
| stat_rd | input | 1 | Status read strobe (clears status) |
| fifo_af | input | 1 | Sample buffer almost-full level |
| fifo_rd | input | 1 | Sample buffer data read strobe |
| af_edge_mode | input | 1 | 0: level policy, 1: edge policy for almost-full |
| af_rdclr_en | input | 1 | Let data reads clear almost-full |
| thr_hi | output | 16 | Current high threshold |
| thr_lo | output | 16 | Current low threshold |
| ien | output | 3 | Current interrupt enables |
| status | output | 3 | Sticky status: bit0 high, bit1 low, bit2 almost-full |
| alarm_flag | output | 1 | Any enabled status bit set |
| int_pull_low | output | 1 | Drive interrupt pin low (open-drain enable) |

## Verification
The assertions assume that the strobes are synchronous single-cycle pulses sampled on the rising edge, and that `fifo_af` is a clean level that changes only at clock edges. The edge-policy check also assumes that the level is defined in the cycle before each sample. The bench drives every input on the falling edge and holds the almost-full level steady across each window in which it checks the edge policy. Threshold writes are separated by at least one cycle from the samples they are meant to govern, so each compare sees a threshold that has settled.

// File: rtl/tac_pkg.sv
package tac_pkg;
   localparam int ST_HI = 0;
   localparam int ST_LO = 1;
   localparam int ST_AF = 2;
   localparam int ST_N  = 3;

   typedef enum logic [1:0] {
      PM_HIZ_IN = 2'b00,
      PM_OD_OUT = 2'b01,
      PM_PD_IN  = 2'b10,
      PM_SPEC   = 2'b11
   } pin_mode_e;
endpackage

// File: rtl/tac_thresh_cmp.sv
module tac_thresh_cmp #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_hi,
   input  logic         wr_lo,
   input  logic [W-1:0] wdata,
   input  logic         smp_valid,
   input  logic [W-1:0] smp_data,
   output logic [W-1:0] thr_hi,
   output logic [W-1:0] thr_lo,
   output logic         hit_hi,
   output logic         hit_lo
);
   localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};
   localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};

   generate
      if (W < 2) begin : g_bad_w
         $error("tac_thresh_cmp: W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         thr_hi <= MAX_POS;
         thr_lo <= MIN_NEG;
      end else begin
         if (wr_hi) thr_hi <= wdata;
         if (wr_lo) thr_lo <= wdata;
      end
   end

   always_comb begin
      hit_hi = smp_valid && ($signed(smp_data) > $signed(thr_hi));
      hit_lo = smp_valid && ($signed(smp_data) < $signed(thr_lo));
   end
endmodule

// File: rtl/tac_af_trig.sv
module tac_af_trig (
   input  logic clk,
   input  logic rst_n,
   input  logic edge_mode,
   input  logic af_lvl,
   input  logic smp_valid,
   output logic af_set
);
   logic af_prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) af_prev_q <= 1'b0;
      else        af_prev_q <= af_lvl;
   end

   always_comb begin
      if (edge_mode) af_set = af_lvl && !af_prev_q;
      else           af_set = af_lvl && smp_valid;
   end

   // R8: while the level persists, edge policy raises nothing
   a_r8_edge_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_mode && af_lvl && $past(af_lvl)) |-> !af_set);
endmodule

// File: rtl/tac_sticky_bit.sv
module tac_sticky_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= 1'b0;
      else if (set) q <= 1'b1;
      else if (clr) q <= 1'b0;
   end

   // R10: a set in the same cycle as a clear still leaves the bit set
   a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set |=> q);
   // R4: without a clear the bit holds
   a_r4_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (q && !clr) |=> q);
   a_r4_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !set) |=> !q);
endmodule

// File: rtl/tmp_alarm_ctrl.sv
module tmp_alarm_ctrl
   import tac_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_valid,
   input  logic [DATA_W-1:0] smp_data,
   input  logic              thr_hi_wr,
   input  logic              thr_lo_wr,
   input  logic [DATA_W-1:0] thr_wdata,
   input  logic              ien_wr,
   input  logic [2:0]        ien_wdata,
   input  logic [1:0]        pin_mode,
   input  logic              stat_rd,
   input  logic              fifo_af,
   input  logic              fifo_rd,
   input  logic              af_edge_mode,
   input  logic              af_rdclr_en,
   output logic [DATA_W-1:0] thr_hi,
   output logic [DATA_W-1:0] thr_lo,
   output logic [2:0]        ien,
   output logic [2:0]        status,
   output logic              alarm_flag,
   output logic              int_pull_low
);
   generate
      if (ST_N != 3) begin : g_bad_n
         $error("tmp_alarm_ctrl: status width must match port width");
      end
   endgenerate

   logic             hit_hi, hit_lo, af_set;
   logic [ST_N-1:0]  set_v, clr_v;

   tac_thresh_cmp #(.W(DATA_W)) cmp_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_hi    (thr_hi_wr),
      .wr_lo    (thr_lo_wr),
      .wdata    (thr_wdata),
      .smp_valid(smp_valid),
      .smp_data (smp_data),
      .thr_hi   (thr_hi),
      .thr_lo   (thr_lo),
      .hit_hi   (hit_hi),
      .hit_lo   (hit_lo)
   );

   tac_af_trig af_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .edge_mode(af_edge_mode),
      .af_lvl   (fifo_af),
      .smp_valid(smp_valid),
      .af_set   (af_set)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ien <= '0;
      else if (ien_wr) ien <= ien_wdata;
   end

   always_comb begin
      set_v        = '0;
      set_v[ST_HI] = hit_hi;
      set_v[ST_LO] = hit_lo;
      set_v[ST_AF] = af_set;
   end

   genvar gi;
   generate
      for (gi = 0; gi < ST_N; gi++) begin : g_st
         if (gi == ST_AF) begin : g_af_clr
            assign clr_v[gi] = stat_rd || (fifo_rd && af_rdclr_en);
         end else begin : g_plain_clr
            assign clr_v[gi] = stat_rd;
         end
         tac_sticky_bit bit_i (
            .clk  (clk),
            .rst_n(rst_n),
            .set  (set_v[gi]),
            .clr  (clr_v[gi]),
            .q    (status[gi])
         );
      end
   endgenerate

   always_comb begin
      alarm_flag   = |(status & ien);
      int_pull_low = alarm_flag && (pin_mode_e'(pin_mode) == PM_SPEC);
   end

   // R2: above-threshold result latches the high bit
   a_r2_hi_latch: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid && ($signed(smp_data) > $signed(thr_hi))) |=> status[ST_HI]);
   // R3: below-threshold result latches the low bit
   a_r3_lo_latch: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid && ($signed(smp_data) < $signed(thr_lo))) |=> status[ST_LO]);
   // R6: pin only pulled in special-function mode with an enabled bit set
   a_r6_pin_gate: assert property (@(posedge clk) disable iff (!rst_n)
      int_pull_low |-> (pin_mode == 2'b11) && ((status & ien) != 3'b000));
   // R9: a data read with the option off leaves almost-full alone
   a_r9_rd_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (status[ST_AF] && fifo_rd && !af_rdclr_en && !stat_rd) |=> status[ST_AF]);
endmodule

// File: tb/tmp_alarm_ctrl_tb_top.sv
module tmp_alarm_ctrl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        smp_valid = 0, thr_hi_wr = 0, thr_lo_wr = 0, ien_wr = 0;
   logic [15:0] smp_data = '0, thr_wdata = '0;
   logic [2:0]  ien_wdata = '0;
   logic [1:0]  pin_mode = 2'b10;
   logic        stat_rd = 0, fifo_af = 0, fifo_rd = 0, af_edge_mode = 0, af_rdclr_en = 0;
   logic [15:0] thr_hi, thr_lo;
   logic [2:0]  ien, status;
   logic        alarm_flag, int_pull_low;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #10 clk = ~clk;

   tmp_alarm_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
      .thr_hi_wr(thr_hi_wr), .thr_lo_wr(thr_lo_wr), .thr_wdata(thr_wdata),
      .ien_wr(ien_wr), .ien_wdata(ien_wdata), .pin_mode(pin_mode),
      .stat_rd(stat_rd), .fifo_af(fifo_af), .fifo_rd(fifo_rd),
      .af_edge_mode(af_edge_mode), .af_rdclr_en(af_rdclr_en),
      .thr_hi(thr_hi), .thr_lo(thr_lo), .ien(ien), .status(status),
      .alarm_flag(alarm_flag), .int_pull_low(int_pull_low)
   );

   // {high threshold, low threshold, sample, expected {lo,hi}}
   localparam logic [49:0] VEC [10] = '{
      {16'h7FFF, 16'h8000, 16'h1CE8, 2'b00},
      {16'h1CE8, 16'h0000, 16'h1CE9, 2'b01},
      {16'h1CE8, 16'h0000, 16'h1CE8, 2'b00},
      {16'h1CE8, 16'h0000, 16'hFFFF, 2'b10},
      {16'h0000, 16'hFF38, 16'hFF37, 2'b10},
      {16'h0000, 16'hFF38, 16'hFF38, 2'b00},
      {16'hFF38, 16'h8000, 16'hFFFF, 2'b01},
      {16'h7FFF, 16'h8000, 16'h8000, 2'b00},
      {16'h7FFE, 16'h8001, 16'h7FFF, 2'b01},
      {16'h7FFE, 16'h8001, 16'h8000, 2'b10}
   };

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic cyc();
      @(negedge clk);
   endtask

   task automatic clear_status();
      stat_rd = 1; cyc(); stat_rd = 0;
   endtask

   task automatic sample(input logic [15:0] d);
      smp_valid = 1; smp_data = d; cyc(); smp_valid = 0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) cyc();
      chk("R1 thr_hi reset", thr_hi, 16'h7FFF);
      chk("R1 thr_lo reset", thr_lo, 16'h8000);
      chk("R1 ien reset", {13'd0, ien}, 16'd0);
      chk("R1 status reset", {13'd0, status}, 16'd0);
      chk("R1 pin released", {15'd0, int_pull_low}, 16'd0);
      rst_n = 1;
      cyc();

      // R2 R3 R11 table walk
      for (int i = 0; i < 10; i++) begin
         thr_hi_wr = 1; thr_wdata = VEC[i][49:34]; cyc(); thr_hi_wr = 0;
         thr_lo_wr = 1; thr_wdata = VEC[i][33:18]; stat_rd = 1; cyc();
         thr_lo_wr = 0; stat_rd = 0;
         chk("R11 thr_hi load", thr_hi, VEC[i][49:34]);
         chk("R11 thr_lo load", thr_lo, VEC[i][33:18]);
         sample(VEC[i][17:2]);
         chk("R2 R3 compare", {14'd0, status[1:0]}, {14'd0, VEC[i][1:0]});
      end

      // R4 sticky then clear
      thr_hi_wr = 1; thr_wdata = 16'h1CE8; cyc();
      thr_hi_wr = 0; thr_lo_wr = 1; thr_wdata = 16'h0000; cyc(); thr_lo_wr = 0;
      clear_status();
      sample(16'h2000);
      sample(16'h1000);
      chk("R4 sticky after in-range", {13'd0, status}, 16'd1);
      clear_status();
      chk("R4 status read clears", {13'd0, status}, 16'd0);

      // R5 R6 gating
      sample(16'h2000);
      ien_wr = 1; ien_wdata = 3'b010; cyc(); ien_wr = 0;
      chk("R5 disabled bit no flag", {15'd0, alarm_flag}, 16'd0);
      ien_wr = 1; ien_wdata = 3'b001; cyc(); ien_wr = 0;
      chk("R11 ien load", {13'd0, ien}, 16'd1);
      chk("R5 enabled bit flag", {15'd0, alarm_flag}, 16'd1);
      pin_mode = 2'b10; #1;
      chk("R6 mode 10 released", {15'd0, int_pull_low}, 16'd0);
      pin_mode = 2'b00; #1;
      chk("R6 mode 00 released", {15'd0, int_pull_low}, 16'd0);
      pin_mode = 2'b01; #1;
      chk("R6 mode 01 released", {15'd0, int_pull_low}, 16'd0);
      pin_mode = 2'b11; #1;
      chk("R6 mode 11 pulls low", {15'd0, int_pull_low}, 16'd1);
      cyc();

      // R10 set wins over read in same cycle
      stat_rd = 1; smp_valid = 1; smp_data = 16'h2000; cyc();
      stat_rd = 0; smp_valid = 0;
      chk("R10 set beats clear", {13'd0, status}, 16'd1);
      chk("R6 pin still low", {15'd0, int_pull_low}, 16'd1);
      clear_status();
      chk("R6 pin released after read", {15'd0, int_pull_low}, 16'd0);

      // R7 level policy
      af_edge_mode = 0; fifo_af = 1; cyc();
      chk("R7 no set without sample", {13'd0, status}, 16'd0);
      sample(16'h1000);
      chk("R7 level set", {13'd0, status}, 16'd4);
      clear_status();
      sample(16'h1000);
      chk("R7 level re-set on persist", {13'd0, status}, 16'd4);
      clear_status();

      // R8 edge policy (fifo_af already high)
      af_edge_mode = 1;
      sample(16'h1000);
      chk("R8 persist no set", {13'd0, status}, 16'd0);
      fifo_af = 0; cyc();
      fifo_af = 1; cyc();
      chk("R8 rising entry sets", {13'd0, status}, 16'd4);
      clear_status();
      sample(16'h1000);
      chk("R8 no re-set while held", {13'd0, status}, 16'd0);

      // R9 data-read clearing of almost-full
      fifo_af = 0; cyc();
      fifo_af = 1; smp_valid = 1; smp_data = 16'h2000; cyc(); smp_valid = 0;
      chk("R9 setup hi+af", {13'd0, status}, 16'd5);
      af_rdclr_en = 0; fifo_rd = 1; cyc(); fifo_rd = 0;
      chk("R9 read ignored when off", {13'd0, status}, 16'd5);
      af_rdclr_en = 1; fifo_rd = 1; cyc(); fifo_rd = 0;
      chk("R9 read clears af only", {13'd0, status}, 16'd1);

      cyc();
      finish_run();
   end
endmodule